// File: doc/BRIEF.md
# PWM Channel Period Counter

This block is the timebase of one pulse-width-modulation channel. A clock-enable chain picks how fast the channel counter advances. A power-of-two prescaler divides the system clock by 2^k. One of two programmable linear dividers (A or B) may follow it. The counter then runs against a programmable period. In left-aligned mode it counts up and wraps. In center-aligned mode it counts up to the period and back down to zero, so for the same settings the waveform is twice as long.

The period value sits in a 24-bit register behind a write port. The port accepts a write only when both protect-status inputs, one for software and one for hardware, are low. Only the low 16 bits of the register feed the counter. A new value is picked up at the next period boundary, so a cycle in progress always completes. The outputs are the live counter value, a one-clock period-event pulse and a PWM level that is high while the counter is below the duty input.

Top module: `pwm_period_chan`

## Requirements
- R1: After a synchronous reset, `cnt` is 0, `period_evt` is 0, `pwm_out` is 0 and `per_rdata` is 0.
- R2: With no linear divider (`div_sel` 0 or 3), the counter advances once every 2^`pre_sel` clocks, where `pre_sel` is 0..10. Any `pre_sel` above 10 behaves as 10.
- R3: `div_sel` 1 inserts divider A and `div_sel` 2 inserts divider B after the prescaler. The counter then advances once every 2^`pre_sel` × N clocks, where N is `div_a` or `div_b`.
- R4: In left-aligned mode (`align_center` = 0) with period P ≥ 1, the counter steps 0,1,…,P-1 and then wraps to 0. `period_evt` is high for exactly the one clock in which the counter has just wrapped to 0. Events are therefore spaced 2^`pre_sel` × N × P clocks apart, with N = 1 when no divider is selected.
- R5: In center-aligned mode (`align_center` = 1) with P ≥ 1, the counter steps up from 0 to P and back down to 0. `period_evt` is high for the one clock in which it has just returned to 0, so events are 2 × 2^`pre_sel` × N × P clocks apart.
- R6: When `per_wr` is high, `per_wdata` is stored only if `prot_sw` and `prot_hw` are both 0. Otherwise the register keeps its value and the counter is not disturbed.
- R7: `per_rdata` returns all 24 stored bits. The counter uses only bits 15:0 as P.
- R8: A period value written mid-cycle takes effect only after the next period event. The cycle in progress keeps the old length.
- R9: A selected divider value of 0 stops the counter: `cnt` holds and no `period_evt` occurs.
- R10: `pwm_out` is 1 exactly when `cnt` is below `duty`.
- R11: While the active period is 0, the counter stays at 0 and produces no event. The stored period is picked up on the next counter advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| per_wr | input | 1 | Period register write strobe |
| per_wdata | input | 24 | Period register write data |
| per_rdata | output | 24 | Period register read data |
| prot_sw | input | 1 | Software write-protect status |
| prot_hw | input | 1 | Hardware write-protect status |
| pre_sel | input | 4 | Prescaler exponent (divide by 2^pre_sel, clamped at 10) |
| div_sel | input | 2 | Counter clock source: 0/3 prescaler only, 1 divider A, 2 divider B |
| div_a | input | 8 | Linear divider A value (0 stops the clock) |
| div_b | input | 8 | Linear divider B value (0 stops the clock) |
| align_center | input | 1 | 0 left-aligned, 1 center-aligned |
| duty | input | 16 | Compare value for the PWM level |
| cnt | output | 16 | Channel counter value |
| period_evt | output | 1 | One-clock pulse at each period boundary |
| pwm_out | output | 1 | PWM level, high while cnt < duty |

## Verification
The bench uses the default widths: a 16-bit counter, a 24-bit register, 8-bit dividers and a prescaler ceiling of 10. Because of the full 10-bit prescaler, the clamp at `pre_sel` = 15 produces a 1024-clock tick that can be measured directly. The 24-bit register lets a write with nonzero upper bits show that those bits are kept for read-back but ignored by the counter. Small periods (1 to 10) and small divider values keep each measured event gap within a few thousand clocks. This brings wrap, turnaround, mid-cycle reload and the zero-divider and zero-period corners into every run.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

    localparam int PRE_LIMIT = 10;

    typedef enum logic [1:0] {
        SRC_PRESCALE = 2'd0,
        SRC_DIV_A    = 2'd1,
        SRC_DIV_B    = 2'd2,
        SRC_SPARE    = 2'd3
    } clk_src_e;

    typedef enum logic {
        MODE_LEFT   = 1'b0,
        MODE_CENTER = 1'b1
    } align_e;

    // limit the prescaler exponent to the largest supported setting
    function automatic logic [3:0] clamp_pre(input logic [3:0] sel, input int lim);
        return (int'(sel) > lim) ? 4'(lim) : sel;
    endfunction

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
    parameter int PRE_MAX = 10,
    parameter int SEL_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CW = PRE_MAX;

    logic [CW-1:0] free_cnt;
    logic [CW:0]   pow;
    logic [CW-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) free_cnt <= '0;
        else     free_cnt <= free_cnt + 1'b1;
    end

    always_comb begin
        pow  = (CW+1)'(1) << sel;
        mask = CW'(pow - 1'b1);
    end

    assign tick = ((free_cnt & mask) == mask);

endmodule

// File: rtl/pwm_lin_div.sv
module pwm_lin_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] phase;
    logic             live;
    logic             last;

    assign live = (div != '0);
    assign last = (phase >= div - 1'b1);
    assign tick = en && live && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (en && live) begin
            phase <= last ? '0 : phase + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  align_e           mode,
    input  logic [CNT_W-1:0] per_next,
    output logic [CNT_W-1:0] cnt,
    output logic             evt
);
    logic [CNT_W-1:0] per_act;
    logic             rising;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            per_act <= '0;
            rising  <= 1'b1;
            evt     <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (tick) begin
                if (per_act == '0) begin
                    cnt     <= '0;
                    rising  <= 1'b1;
                    per_act <= per_next;
                end else if (mode == MODE_LEFT) begin
                    if (cnt >= per_act - CNT_W'(1)) begin
                        cnt     <= '0;
                        evt     <= 1'b1;
                        rising  <= 1'b1;
                        per_act <= per_next;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end else if (rising) begin
                    if (cnt >= per_act) begin
                        cnt    <= cnt - CNT_W'(1);
                        rising <= 1'b0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                        if (cnt + CNT_W'(1) == per_act) rising <= 1'b0;
                    end
                end else begin
                    if (cnt <= CNT_W'(1)) begin
                        cnt     <= '0;
                        evt     <= 1'b1;
                        rising  <= 1'b1;
                        per_act <= per_next;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/pwm_period_chan.sv
module pwm_period_chan
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int REG_W   = 24,
    parameter int DIV_W   = 8,
    parameter int SEL_W   = 4,
    parameter int PRE_MAX = PRE_LIMIT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             per_wr,
    input  logic [REG_W-1:0] per_wdata,
    output logic [REG_W-1:0] per_rdata,
    input  logic             prot_sw,
    input  logic             prot_hw,
    input  logic [SEL_W-1:0] pre_sel,
    input  logic [1:0]       div_sel,
    input  logic [DIV_W-1:0] div_a,
    input  logic [DIV_W-1:0] div_b,
    input  logic             align_center,
    input  logic [CNT_W-1:0] duty,
    output logic [CNT_W-1:0] cnt,
    output logic             period_evt,
    output logic             pwm_out
);
    localparam int NDIV = 2;

    logic [REG_W-1:0] per_reg;
    logic             wr_ok;
    logic [SEL_W-1:0] pre_eff;
    logic             pre_tick;
    logic [DIV_W-1:0] div_val  [NDIV];
    logic [NDIV-1:0]  div_tick;
    logic             ctr_tick;

    // protected period register
    assign wr_ok = per_wr && !prot_sw && !prot_hw;

    always_ff @(posedge clk) begin
        if (rst)        per_reg <= '0;
        else if (wr_ok) per_reg <= per_wdata;
    end

    assign per_rdata = per_reg;

    // tick-enable chain
    assign pre_eff = SEL_W'(clamp_pre(4'(pre_sel), PRE_MAX));

    pwm_prescale #(.PRE_MAX(PRE_MAX), .SEL_W(SEL_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .sel  (pre_eff),
        .tick (pre_tick)
    );

    assign div_val[0] = div_a;
    assign div_val[1] = div_b;

    for (genvar g = 0; g < NDIV; g++) begin : g_div
        pwm_lin_div #(.DIV_W(DIV_W)) u_div (
            .clk  (clk),
            .rst  (rst),
            .en   (pre_tick),
            .div  (div_val[g]),
            .tick (div_tick[g])
        );
    end

    always_comb begin
        case (clk_src_e'(div_sel))
            SRC_DIV_A: ctr_tick = div_tick[0];
            SRC_DIV_B: ctr_tick = div_tick[1];
            default:   ctr_tick = pre_tick;
        endcase
    end

    pwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .tick     (ctr_tick),
        .mode     (align_e'(align_center)),
        .per_next (per_reg[CNT_W-1:0]),
        .cnt      (cnt),
        .evt      (period_evt)
    );

    assign pwm_out = (cnt < duty);

endmodule

// File: rtl/pwm_period_chan_chk.sv
module pwm_period_chan_chk #(
    parameter int CNT_W = 16,
    parameter int REG_W = 24,
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             per_wr,
    input logic [REG_W-1:0] per_wdata,
    input logic [REG_W-1:0] per_rdata,
    input logic             prot_sw,
    input logic             prot_hw,
    input logic [1:0]       div_sel,
    input logic [DIV_W-1:0] div_a,
    input logic [DIV_W-1:0] div_b,
    input logic             align_center,
    input logic [CNT_W-1:0] cnt,
    input logic             period_evt
);
    assert_evt_at_zero_R4: assert property (@(posedge clk) disable iff (rst)
        period_evt |-> (cnt == '0));

    assert_left_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!align_center && $past(!align_center) && !$stable(cnt))
        |-> (cnt == $past(cnt) + CNT_W'(1) || cnt == '0));

    assert_center_step_R5: assert property (@(posedge clk) disable iff (rst)
        (align_center && $past(align_center) && !$stable(cnt))
        |-> (cnt == $past(cnt) + CNT_W'(1) || cnt == $past(cnt) - CNT_W'(1)));

    assert_write_taken_R6: assert property (@(posedge clk) disable iff (rst)
        (per_wr && !prot_sw && !prot_hw) |=> (per_rdata == $past(per_wdata)));

    assert_write_blocked_R6: assert property (@(posedge clk) disable iff (rst)
        (per_wr && (prot_sw || prot_hw)) |=> $stable(per_rdata));

    assert_clock_off_a_R9: assert property (@(posedge clk) disable iff (rst)
        (div_sel == 2'd1 && div_a == '0) |=> ($stable(cnt) && !period_evt));

    assert_clock_off_b_R9: assert property (@(posedge clk) disable iff (rst)
        (div_sel == 2'd2 && div_b == '0) |=> ($stable(cnt) && !period_evt));

endmodule

bind pwm_period_chan pwm_period_chan_chk #(
    .CNT_W(CNT_W), .REG_W(REG_W), .DIV_W(DIV_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .per_wr       (per_wr),
    .per_wdata    (per_wdata),
    .per_rdata    (per_rdata),
    .prot_sw      (prot_sw),
    .prot_hw      (prot_hw),
    .div_sel      (div_sel),
    .div_a        (div_a),
    .div_b        (div_b),
    .align_center (align_center),
    .cnt          (cnt),
    .period_evt   (period_evt)
);

// File: tb/pwm_period_chan_bench.sv
`timescale 1ns/1ps
module pwm_period_chan_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        per_wr = 1'b0;
    logic [23:0] per_wdata = '0;
    logic [23:0] per_rdata;
    logic        prot_sw = 1'b0;
    logic        prot_hw = 1'b0;
    logic [3:0]  pre_sel = '0;
    logic [1:0]  div_sel = '0;
    logic [7:0]  div_a = 8'd1;
    logic [7:0]  div_b = 8'd1;
    logic        align_center = 1'b0;
    logic [15:0] duty = '0;
    logic [15:0] cnt;
    logic        period_evt;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwm_period_chan u_pwm_period_chan (
        .clk(clk), .rst(rst), .per_wr(per_wr), .per_wdata(per_wdata),
        .per_rdata(per_rdata), .prot_sw(prot_sw), .prot_hw(prot_hw),
        .pre_sel(pre_sel), .div_sel(div_sel), .div_a(div_a), .div_b(div_b),
        .align_center(align_center), .duty(duty), .cnt(cnt),
        .period_evt(period_evt), .pwm_out(pwm_out)
    );

    // ---------------- behavioural reference ----------------
    int m_clk, m_pa, m_pb, m_cnt, m_act, m_reg;
    bit m_up, m_evt;

    always @(posedge clk) begin
        if (rst) begin
            m_clk = 0; m_pa = 0; m_pb = 0; m_cnt = 0; m_act = 0;
            m_reg = 0; m_up = 1; m_evt = 0;
        end else begin
            int x, per;
            bit pt, ta, tb, t;
            x  = 1 << ((pre_sel > 10) ? 10 : pre_sel);
            pt = ((m_clk % x) == x - 1);
            m_clk = (m_clk + 1) % 1024;
            ta = 0; tb = 0;
            if (pt && div_a != 0) begin
                if (m_pa >= div_a - 1) begin ta = 1; m_pa = 0; end else m_pa++;
            end
            if (pt && div_b != 0) begin
                if (m_pb >= div_b - 1) begin tb = 1; m_pb = 0; end else m_pb++;
            end
            t = (div_sel == 1) ? ta : (div_sel == 2) ? tb : pt;
            per = m_reg & 16'hFFFF;
            m_evt = 0;
            if (t) begin
                if (m_act == 0) begin
                    m_cnt = 0; m_up = 1; m_act = per;
                end else if (!align_center) begin
                    if (m_cnt + 1 >= m_act) begin
                        m_cnt = 0; m_evt = 1; m_up = 1; m_act = per;
                    end else m_cnt++;
                end else if (m_up) begin
                    if (m_cnt >= m_act) begin m_cnt--; m_up = 0; end
                    else begin m_cnt++; if (m_cnt == m_act) m_up = 0; end
                end else begin
                    if (m_cnt <= 1) begin
                        m_cnt = 0; m_evt = 1; m_up = 1; m_act = per;
                    end else m_cnt--;
                end
            end
            if (per_wr && !prot_sw && !prot_hw) m_reg = int'(per_wdata);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(int'(cnt) == m_cnt, "R4 R5 counter vs model", cnt, m_cnt);
            check(period_evt == m_evt, "R4 R5 event vs model", period_evt, m_evt);
            check(pwm_out == (m_cnt < int'(duty)), "R10 pwm level", pwm_out, m_cnt < int'(duty));
            check(int'(per_rdata) == m_reg, "R6 R7 readback vs model", per_rdata, m_reg);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_per(input logic [23:0] v);
        per_wdata = v; per_wr = 1'b1;
        step(1);
        per_wr = 1'b0;
    endtask

    task automatic wait_evt();
        do @(negedge clk); while (!period_evt);
    endtask

    // clocks between two consecutive events, after discarding two
    task automatic gap_check(input int exp, input string tag);
        int g;
        wait_evt(); wait_evt();
        g = 0;
        do begin @(negedge clk); g++; end while (!period_evt);
        check(g == exp, tag, g, exp);
        step(1);
    endtask

    task automatic finish_up();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(5ns * 190000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        step(3);
        // R1: reset state
        check(cnt == 0 && !period_evt && !pwm_out && per_rdata == 0,
              "R1 reset outputs", {cnt, 3'b0, period_evt, pwm_out}, 0);
        rst = 1'b0;
        step(2);

        // R6: blocked writes, R11: period 0 holds counter at 0
        prot_sw = 1'b1; write_per(24'd7); step(1);
        check(per_rdata == 0, "R6 write blocked by sw", per_rdata, 0);
        prot_sw = 1'b0; prot_hw = 1'b1; write_per(24'd7); step(1);
        check(per_rdata == 0, "R6 write blocked by hw", per_rdata, 0);
        prot_hw = 1'b0;
        step(20);
        check(cnt == 0, "R11 zero period holds", cnt, 0);

        // R7: upper bits stored, counter uses low 16 bits
        write_per(24'hAB0005); step(1);
        check(per_rdata == 24'hAB0005, "R7 full readback", per_rdata, 24'hAB0005);
        gap_check(5, "R4 R7 left period 5 x1");

        // R2: prescaler
        pre_sel = 4'd2; gap_check(20, "R2 left prescale 4");
        write_per(24'd3); pre_sel = 4'd15; gap_check(3072, "R2 clamp at 1024");

        // R3: linear dividers
        pre_sel = 4'd1; write_per(24'd4);
        div_a = 8'd3; div_sel = 2'd1; gap_check(24, "R3 divider A");
        div_b = 8'd5; div_sel = 2'd2; gap_check(40, "R3 divider B");
        div_sel = 2'd3; gap_check(8, "R3 spare select = none");

        // R5: center-aligned
        pre_sel = 4'd0; div_sel = 2'd0; align_center = 1'b1;
        gap_check(8, "R5 center period 4");
        div_b = 8'd2; div_sel = 2'd2; gap_check(16, "R5 center with divider B");
        div_sel = 2'd0; write_per(24'd1); gap_check(2, "R5 center period 1");

        // R10: symmetric pulse width in center mode
        write_per(24'd8); duty = 16'd3;
        wait_evt(); wait_evt();
        begin
            int hi = 0;
            for (int i = 0; i < 16; i++) begin
                if (pwm_out) hi++;
                @(negedge clk);
            end
            check(hi == 5, "R10 center high clocks", hi, 5);
        end
        step(1);

        // R10 left: high for duty clocks
        align_center = 1'b0;
        wait_evt(); wait_evt();
        begin
            int hi = 0;
            for (int i = 0; i < 8; i++) begin
                if (pwm_out) hi++;
                @(negedge clk);
            end
            check(hi == 3, "R10 left high clocks", hi, 3);
        end
        step(1);

        // R8: mid-cycle write keeps current length
        write_per(24'd10); wait_evt(); wait_evt(); step(2);
        write_per(24'd4);
        begin
            int g = 0;
            do begin @(negedge clk); g++; end while (!period_evt);
            check(g == 8, "R8 current cycle kept", g, 8);
            g = 0;
            do begin @(negedge clk); g++; end while (!period_evt);
            check(g == 4, "R8 new period after event", g, 4);
        end
        step(1);

        // R6: blocked write does not disturb running counter
        prot_hw = 1'b1; write_per(24'd9); prot_hw = 1'b0;
        gap_check(4, "R6 blocked write keeps period");

        // R9: zero divider stops the clock
        step(3);
        div_a = 8'd0; div_sel = 2'd1; step(1);
        begin
            logic [15:0] hold = cnt;
            int ev = 0;
            for (int i = 0; i < 50; i++) begin
                @(negedge clk);
                if (period_evt) ev++;
            end
            check(cnt == hold, "R9 counter frozen", cnt, hold);
            check(ev == 0, "R9 no events", ev, 0);
        end
        step(1);
        div_sel = 2'd0;

        // R11: loading 0 stops at next event
        write_per(24'd0); wait_evt(); step(30);
        check(cnt == 0, "R11 zero period counter", cnt, 0);
        write_per(24'd6); gap_check(6, "R11 restart after zero");

        finish_up();
    end

endmodule